// File: doc/BRIEF.md
# Processor Operating Mode Decoder

This block derives the execution mode of an x86-style core from a handful of architectural control bits. The inputs are the long-mode-active flag, the paging-enable and protection-enable control bits, the virtual-8086 flag, and attribute bits taken from the code and stack segment descriptors: the code segment's long bit, its default-size bit and its privilege level, plus the stack segment's default-size bit.

From these it produces a single registered record for the instruction decoder. The record holds the mode, a submode, the current privilege level, copies of the paging and protection bits, and five size codes. The size codes give the default and alternate operand size, the default and alternate address size, and the stack width. Each size code is the log2 of the byte count: 1 is 16-bit, 2 is 32-bit and 3 is 64-bit.

The record changes only on a one-cycle recompute strobe. A control path turns the strobe and the reset into a load or clear strobe for the datapath. The datapath evaluates the priority chain and holds the result.

Top module: `opmode_decoder`

## Requirements
- R1: When lmaActive is 1, modeLong becomes 1. subMode is then 4 (64-bit) if csLongBit is 1, and 3 (compatibility) if csLongBit is 0.
- R2: When lmaActive is 0, modeLong becomes 0. subMode is then 0 (real) if protEn is 0, 1 (virtual-8086) if protEn is 1 and v86Flag is 1, and 2 (protected) if protEn is 1 and v86Flag is 0.
- R3: curPriv equals csPriv, pagingOn equals pagingEn, and protOn equals protEn.
- R4: If the submode is 64-bit or csDefaultBig is 1, the operand size is default 2 and alternate 1. Otherwise it is default 1 and alternate 2.
- R5: The address size is default 3 and alternate 2 in 64-bit submode. Outside that submode it is default 2 and alternate 1 if csDefaultBig is 1, and default 1 and alternate 2 if it is 0.
- R6: stackSize is 3 in 64-bit submode. Outside that submode it is 2 if ssDefaultBig is 1, and 1 if it is 0.
- R7: Outputs take the decoded value of the inputs sampled at a clock edge where recompute is 1, and show it from that edge on. They do not change at any edge where recompute is 0, whatever the inputs do.
- R8: A clock edge with rst at 1 sets the outputs to the all-zero-input result, and this has priority over recompute. That result is modeLong 0, subMode 0, curPriv 0, pagingOn 0, protOn 0, operand and address size default 1 and alternate 2, and stackSize 1.
- R9: No size output is ever 0 outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| recompute | input | 1 | Strobe: capture a new decode |
| lmaActive | input | 1 | Long mode active flag |
| pagingEn | input | 1 | Paging enable control bit |
| protEn | input | 1 | Protection enable control bit |
| v86Flag | input | 1 | Virtual-8086 flag |
| csLongBit | input | 1 | Code segment long attribute |
| csDefaultBig | input | 1 | Code segment default-size attribute |
| csPriv | input | 2 | Code segment privilege level |
| ssDefaultBig | input | 1 | Stack segment default-size attribute |
| modeLong | output | 1 | 0 legacy, 1 long |
| subMode | output | 3 | 0 real, 1 v86, 2 protected, 3 compat, 4 64-bit |
| curPriv | output | 2 | Current privilege level |
| pagingOn | output | 1 | Registered paging flag |
| protOn | output | 1 | Registered protection flag |
| opDefault | output | 2 | Default operand size code |
| opAlternate | output | 2 | Alternate operand size code |
| addrDefault | output | 2 | Default address size code |
| addrAlternate | output | 2 | Alternate address size code |
| stackSize | output | 2 | Stack size code |

## Verification
The assertions assume that every input is a known 0 or 1 at any edge where recompute is high. They also assume that rst is high from time zero until the first edge. They do not assume that the input combination is architecturally consistent: long mode active with protection off is decoded the same way as any other combination. The stimulus changes inputs only on the falling clock edge. It walks all 512 combinations of the nine input bits, and between strobes it changes the inputs with recompute low to show that the held result ignores them.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  localparam int PRIV_W = 2;
  localparam int SIZE_W = 2;
  localparam int SUB_W  = 3;

  typedef enum logic [SUB_W-1:0] {
    SUB_REAL   = 3'd0,
    SUB_V86    = 3'd1,
    SUB_PROT   = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_LONG64 = 3'd4
  } subMode_e;

  typedef logic [SIZE_W-1:0] sizeCode_t;
  localparam sizeCode_t SZ16 = 2'd1;
  localparam sizeCode_t SZ32 = 2'd2;
  localparam sizeCode_t SZ64 = 2'd3;

  typedef struct packed {
    logic              modeLong;
    subMode_e          subMode;
    logic [PRIV_W-1:0] priv;
    logic              paging;
    logic              prot;
    sizeCode_t         opDef;
    sizeCode_t         opAlt;
    sizeCode_t         adDef;
    sizeCode_t         adAlt;
    sizeCode_t         stk;
  } modeState_t;

  typedef struct packed {
    logic clear;
    logic load;
  } ctlStrobe_t;

  localparam modeState_t RESET_STATE = '{
    modeLong: 1'b0, subMode: SUB_REAL, priv: '0, paging: 1'b0, prot: 1'b0,
    opDef: SZ16, opAlt: SZ32, adDef: SZ16, adAlt: SZ32, stk: SZ16
  };
endpackage

// File: rtl/opmode_control.sv
module opmode_control
  import opmode_pkg::*;
(
  input  logic       rst,
  input  logic       recompute,
  output ctlStrobe_t strobe
);
  // Reset wins over a recompute in the same cycle.
  always_comb begin
    strobe.clear = rst;
    strobe.load  = recompute & ~rst;
  end
endmodule

// File: rtl/opmode_datapath.sv
module opmode_datapath
  import opmode_pkg::*;
(
  input  logic              clk,
  input  ctlStrobe_t        strobe,
  input  logic              lmaActive,
  input  logic              pagingEn,
  input  logic              protEn,
  input  logic              v86Flag,
  input  logic              csLongBit,
  input  logic              csDefaultBig,
  input  logic [PRIV_W-1:0] csPriv,
  input  logic              ssDefaultBig,
  output modeState_t        state
);
  modeState_t nextState;
  logic       is64;

  // Mode and submode selection.
  subMode_e subSel;
  always_comb begin
    if (lmaActive)   subSel = csLongBit ? SUB_LONG64 : SUB_COMPAT;
    else if (!protEn) subSel = SUB_REAL;
    else              subSel = v86Flag ? SUB_V86 : SUB_PROT;
  end

  assign is64 = (subSel == SUB_LONG64);

  // Layered size priority: 64-bit submode, then segment default bit, then 16-bit.
  always_comb begin
    nextState          = RESET_STATE;
    nextState.modeLong = lmaActive;
    nextState.subMode  = subSel;
    nextState.priv     = csPriv;
    nextState.paging   = pagingEn;
    nextState.prot     = protEn;

    if (is64 || csDefaultBig) begin
      nextState.opDef = SZ32;
      nextState.opAlt = SZ16;
    end else begin
      nextState.opDef = SZ16;
      nextState.opAlt = SZ32;
    end

    if (is64) begin
      nextState.adDef = SZ64;
      nextState.adAlt = SZ32;
    end else if (csDefaultBig) begin
      nextState.adDef = SZ32;
      nextState.adAlt = SZ16;
    end else begin
      nextState.adDef = SZ16;
      nextState.adAlt = SZ32;
    end

    if (is64)              nextState.stk = SZ64;
    else if (ssDefaultBig) nextState.stk = SZ32;
    else                   nextState.stk = SZ16;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     state <= RESET_STATE;
    else if (strobe.load) state <= nextState;
  end
endmodule

// File: rtl/opmode_decoder.sv
module opmode_decoder
  import opmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       recompute,
  input  logic       lmaActive,
  input  logic       pagingEn,
  input  logic       protEn,
  input  logic       v86Flag,
  input  logic       csLongBit,
  input  logic       csDefaultBig,
  input  logic [1:0] csPriv,
  input  logic       ssDefaultBig,
  output logic       modeLong,
  output logic [2:0] subMode,
  output logic [1:0] curPriv,
  output logic       pagingOn,
  output logic       protOn,
  output logic [1:0] opDefault,
  output logic [1:0] opAlternate,
  output logic [1:0] addrDefault,
  output logic [1:0] addrAlternate,
  output logic [1:0] stackSize
);
  ctlStrobe_t strobe;
  modeState_t state;

  opmode_control ctl_i (
    .rst(rst), .recompute(recompute), .strobe(strobe)
  );

  opmode_datapath dp_i (
    .clk(clk), .strobe(strobe),
    .lmaActive(lmaActive), .pagingEn(pagingEn), .protEn(protEn),
    .v86Flag(v86Flag), .csLongBit(csLongBit), .csDefaultBig(csDefaultBig),
    .csPriv(csPriv), .ssDefaultBig(ssDefaultBig), .state(state)
  );

  assign modeLong      = state.modeLong;
  assign subMode       = state.subMode;
  assign curPriv       = state.priv;
  assign pagingOn      = state.paging;
  assign protOn        = state.prot;
  assign opDefault     = state.opDef;
  assign opAlternate   = state.opAlt;
  assign addrDefault   = state.adDef;
  assign addrAlternate = state.adAlt;
  assign stackSize     = state.stk;
endmodule

// File: rtl/opmode_checker.sv
module opmode_checker (
  input logic       clk,
  input logic       rst,
  input logic       recompute,
  input logic       lmaActive,
  input logic       pagingEn,
  input logic       protEn,
  input logic       v86Flag,
  input logic       csLongBit,
  input logic       csDefaultBig,
  input logic [1:0] csPriv,
  input logic       ssDefaultBig,
  input logic       modeLong,
  input logic [2:0] subMode,
  input logic [1:0] curPriv,
  input logic       pagingOn,
  input logic       protOn,
  input logic [1:0] opDefault,
  input logic [1:0] opAlternate,
  input logic [1:0] addrDefault,
  input logic [1:0] addrAlternate,
  input logic [1:0] stackSize
);
  // R1
  long_mode_chk: assert property (@(posedge clk) disable iff (rst)
    recompute && lmaActive |=> modeLong && (subMode == ($past(csLongBit) ? 3'd4 : 3'd3)));

  // R2
  real_mode_chk: assert property (@(posedge clk) disable iff (rst)
    recompute && !lmaActive && !protEn |=> !modeLong && subMode == 3'd0);

  // R3
  copy_bits_chk: assert property (@(posedge clk) disable iff (rst)
    recompute |=> curPriv == $past(csPriv) && pagingOn == $past(pagingEn) && protOn == $past(protEn));

  // R4
  op_pair_chk: assert property (@(posedge clk) disable iff (rst)
    opAlternate == ((opDefault == 2'd2) ? 2'd1 : 2'd2));

  // R5
  addr64_chk: assert property (@(posedge clk) disable iff (rst)
    subMode == 3'd4 |-> addrDefault == 2'd3 && addrAlternate == 2'd2);

  // R6
  stack64_chk: assert property (@(posedge clk) disable iff (rst)
    subMode == 3'd4 |-> stackSize == 2'd3);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !recompute |=> $stable({modeLong, subMode, curPriv, pagingOn, protOn,
                            opDefault, opAlternate, addrDefault, addrAlternate, stackSize}));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !modeLong && subMode == 3'd0 && curPriv == 2'd0 && opDefault == 2'd1 && stackSize == 2'd1);

  // R9
  nonzero_size_chk: assert property (@(posedge clk) disable iff (rst)
    opDefault != 0 && opAlternate != 0 && addrDefault != 0 && addrAlternate != 0 && stackSize != 0);
endmodule

bind opmode_decoder opmode_checker chk_i (.*);

// File: tb/opmode_decoder_tb.sv
module opmode_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic recompute = 1'b0;
  logic lmaActive = 0, pagingEn = 0, protEn = 0, v86Flag = 0;
  logic csLongBit = 0, csDefaultBig = 0, ssDefaultBig = 0;
  logic [1:0] csPriv = '0;
  logic       modeLong, pagingOn, protOn;
  logic [2:0] subMode;
  logic [1:0] curPriv, opDefault, opAlternate, addrDefault, addrAlternate, stackSize;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opmode_decoder dut_i (.*);

  // Packed expected record: {mode, sub[2:0], priv[1:0], pg, pe, opD, opA, adD, adA, stk}
  function automatic logic [17:0] expectFor(input logic [8:0] v);
    logic lma, pg, pe, vm, csl, csd, ssd;
    logic [1:0] pl;
    logic [2:0] sub;
    logic [1:0] od, oa, ad, aa, st;
    {lma, pg, pe, vm, csl, csd, pl, ssd} = v;
    if (lma) sub = csl ? 3'd4 : 3'd3;
    else if (!pe) sub = 3'd0;
    else sub = vm ? 3'd1 : 3'd2;
    od = (sub == 4 || csd) ? 2'd2 : 2'd1;
    oa = 2'd3 - od;
    if (sub == 4) begin ad = 3; aa = 2; end
    else if (csd) begin ad = 2; aa = 1; end
    else begin ad = 1; aa = 2; end
    st = (sub == 4) ? 2'd3 : (ssd ? 2'd2 : 2'd1);
    return {lma, sub, pl, pg, pe, od, oa, ad, aa, st};
  endfunction

  function automatic logic [17:0] observed();
    return {modeLong, subMode, curPriv, pagingOn, protOn,
            opDefault, opAlternate, addrDefault, addrAlternate, stackSize};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input logic [17:0] exp, input string tag);
    logic [17:0] o;
    o = observed();
    check({tag, " R1/R2 mode"}, int'(o[17:14]), int'(exp[17:14]));
    check({tag, " R3 priv/pg/pe"}, int'(o[13:10]), int'(exp[13:10]));
    check({tag, " R4 operand"}, int'(o[9:6]), int'(exp[9:6]));
    check({tag, " R5 address"}, int'(o[5:2]), int'(exp[5:2]));
    check({tag, " R6 stack"}, int'(o[1:0]), int'(exp[1:0]));
    check({tag, " R9 nonzero"}, int'(o[9:8] != 0 && o[7:6] != 0 && o[5:4] != 0 && o[3:2] != 0 && o[1:0] != 0), 1);
  endtask

  task automatic drive(input logic [8:0] v);
    {lmaActive, pagingEn, protEn, v86Flag, csLongBit, csDefaultBig, csPriv, ssDefaultBig} = v;
  endtask

  initial begin
    logic [17:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs after reset equal the all-zero decode
    check("R8 reset", int'(observed()), int'(expectFor(9'd0)));
    rst = 1'b0;
    held = expectFor(9'd0);
    for (int i = 0; i < 512; i++) begin
      drive(9'(i));
      recompute = 1'b0;
      @(posedge clk); @(negedge clk);
      // R7: new inputs without a strobe leave the outputs alone
      check("R7 hold", int'(observed()), int'(held));
      recompute = 1'b1;
      @(posedge clk); @(negedge clk);
      recompute = 1'b0;
      held = expectFor(9'(i));
      checkAll(held, "R7 sweep");
      if (i % 64 == 7) begin
        // R7: repeated strobe, same inputs, same result
        recompute = 1'b1;
        @(posedge clk); @(negedge clk);
        recompute = 1'b0;
        check("R7 repeat", int'(observed()), int'(held));
      end
    end
    // R8: reset has priority over a simultaneous strobe
    drive(9'h1FF);
    recompute = 1'b1;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 priority", int'(observed()), int'(expectFor(9'd0)));
    rst = 1'b0;
    recompute = 1'b0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule